// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block is the software-visible register file of an I/O interrupt router. A 32-bit memory-mapped bus reaches it through two locations only: a select register that names an internal register, and a data window that reads or writes the register currently named. Behind the window sit an identification register, a read-only version word, an arbitration word that mirrors the identification value, and one 64-bit redirection entry per interrupt input pin. Each entry is reached as two 32-bit halves.

Only the low byte of the bus address is decoded. Window accesses must be exactly four bytes wide. Narrower accesses are ignored and read as zero. The block presents the full redirection table on a flat output for the delivery logic. After every accepted redirection write it raises a one-cycle service request, so that the delivery logic can scan the table again.

Top module: `irq_route_regs`

## Requirements
- R1: Only bus_addr[7:0] is decoded, and the upper address bits have no effect. Offset 0x00 is the select register: a write stores bus_wdata[7:0], and a read returns that value zero-extended, at any access size. Offset 0x10 is the data window. A read at any other offset returns 0, and a write there changes nothing.
- R2: A window access whose bus_size (a byte count) is not 4 is ignored. A write of this kind changes no register, and a read of this kind returns 0.
- R3: With select 0x00 (identification) or 0x02 (arbitration), a window read returns the stored 4-bit ID placed in bits 27:24, with all other bits 0.
- R4: With select 0x01 (version), a window read returns 0x11 ORed with (NUM_PINS-1) in bits 23:16. The default value is 0x00170011.
- R5: A window write with select 0x00 stores bus_wdata[27:24] as the ID. Window writes with select 0x01 or 0x02 change nothing.
- R6: A select value s of 0x10 or above addresses entry (s-0x10)>>1. A select value below 0x03 never does. Select values 0x03 to 0x0F, and any value whose index is NUM_PINS or more (0x40 to 0xFF by default), read as 0, and writes with them are dropped.
- R7: Bit 0 of the select chooses the upper half (1) or the lower half (0) of the entry. A write replaces only that 32-bit half. Entry i is visible on redir_tbl[64*i+63:64*i].
- R8: svc_req is high for exactly the one cycle after each accepted redirection-half write. It stays low after every other access and while the bus is idle.
- R9: After reset, every entry holds 0x0000000000010000 (only the mask bit, bit 16, set), and the select register and the ID are 0.
- R10: bus_rdata is loaded at the clock edge that samples a read and keeps that value until the next read is sampled. Writes and idle cycles do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, sampled on each rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the last sampled read |
| svc_req | output | 1 | One-cycle request to rescan the table |
| redir_tbl | output | NUM_PINS*64 (1536) | All redirection entries, entry 0 in the lowest bits |

## Verification
Every register update, and the loading of bus_rdata, happens at the rising edge that samples the request. svc_req rises at that same edge and falls one edge later. The bench drives each access on a falling edge and deasserts it at the next falling edge. At that falling edge it compares bus_rdata, svc_req and the whole table against a bench model, so every result is read half a cycle after the edge that produced it. Before each new access it first checks that svc_req has dropped during the idle cycle. This catches a pulse that lasts too long or that follows the wrong access.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

   localparam int WORD_W  = 32;
   localparam int ENTRY_W = 64;

   // decoded view of one bus request
   typedef struct packed {
      logic sel_hit;    // select register offset
      logic win_addr;   // window offset, any size
      logic win_hit;    // window offset, full-word size
      logic is_id;
      logic is_ver;
      logic is_arb;
      logic redir_hit;  // in-range redirection half
      logic redir_hi;   // upper half chosen
   } dec_t;

   function automatic logic [WORD_W-1:0] version_word(int ver, int pins, int lsb);
      logic [WORD_W-1:0] w;
      w = WORD_W'(ver) | (WORD_W'(pins - 1) << lsb);
      return w;
   endfunction

endpackage

// File: rtl/irq_route_decode.sv
`timescale 1ns/1ps
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int SEL_W    = 8,
   parameter int NUM_PINS = 24,
   parameter int RED_BASE = 16,
   parameter int SEL_OFF  = 0,
   parameter int WIN_OFF  = 16,
   parameter int ID_SEL   = 0,
   parameter int VER_SEL  = 1,
   parameter int ARB_SEL  = 2
) (
   input  logic [7:0]       off,
   input  logic [2:0]       size,
   input  logic [SEL_W-1:0] sel,
   output dec_t             dec,
   output logic [SEL_W-1:0] idx
);

   localparam logic [SEL_W-1:0] BASE_V = SEL_W'(RED_BASE);
   localparam logic [SEL_W-1:0] PINS_V = SEL_W'(NUM_PINS);

   always_comb begin
      idx           = (sel - BASE_V) >> 1;
      dec           = '0;
      dec.sel_hit   = (off == 8'(SEL_OFF));
      dec.win_addr  = (off == 8'(WIN_OFF));
      dec.win_hit   = dec.win_addr && (size == 3'd4);
      dec.is_id     = dec.win_hit && (sel == SEL_W'(ID_SEL));
      dec.is_ver    = dec.win_hit && (sel == SEL_W'(VER_SEL));
      dec.is_arb    = dec.win_hit && (sel == SEL_W'(ARB_SEL));
      dec.redir_hit = dec.win_hit && (sel >= BASE_V) && (idx < PINS_V);
      dec.redir_hi  = sel[0];
   end

endmodule

// File: rtl/irq_route_entry.sv
`timescale 1ns/1ps
module irq_route_entry #(
   parameter logic [63:0] RST_VAL = 64'h0000_0000_0001_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   output logic [63:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else begin
         if (wr_lo) q[31:0]  <= wdata;
         if (wr_hi) q[63:32] <= wdata;
      end
   end

   AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> $stable(q[63:32])); // R7
   AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> $stable(q[31:0])); // R7

endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int NUM_PINS  = 24,
   parameter int ADDR_W    = 12,
   parameter int SEL_W     = 8,
   parameter int RED_BASE  = 16,
   parameter int SEL_OFF   = 0,
   parameter int WIN_OFF   = 16,
   parameter int ID_LSB    = 24,
   parameter int ID_W      = 4,
   parameter int VER_CONST = 17,
   parameter int ENT_LSB   = 16,
   parameter int MASK_BIT  = 16,
   parameter bit READ_REG  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_req,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [2:0]                 bus_size,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   output logic                       svc_req,
   output logic [NUM_PINS*ENTRY_W-1:0] redir_tbl
);

   localparam logic [31:0] VER_WORD = version_word(VER_CONST, NUM_PINS, ENT_LSB);
   localparam logic [63:0] ENT_RST  = 64'(1) << MASK_BIT;

   // elaboration-time parameter checks
   if (ADDR_W <= 8) begin : g_bad_addr
      $error("ADDR_W must exceed the decoded byte");
   end
   if (NUM_PINS < 1 || (RED_BASE + 2*NUM_PINS) > (1 << SEL_W)) begin : g_bad_pins
      $error("NUM_PINS does not fit the select space");
   end
   if (ID_LSB + ID_W > 32 || MASK_BIT > 63) begin : g_bad_field
      $error("field position out of word");
   end

   logic              unused_addr_hi;
   logic [SEL_W-1:0]  sel_q;
   logic [ID_W-1:0]   id_q;
   logic              svc_q;
   logic [SEL_W-1:0]  idx;
   dec_t              dec;
   logic              acc_wr, acc_rd;
   logic [31:0]       rd_word;
   logic [63:0]       ent [NUM_PINS];

   assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];
   assign acc_wr = bus_req && bus_we;
   assign acc_rd = bus_req && !bus_we;

   irq_route_decode #(
      .SEL_W(SEL_W), .NUM_PINS(NUM_PINS), .RED_BASE(RED_BASE),
      .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF),
      .ID_SEL(0), .VER_SEL(1), .ARB_SEL(2)
   ) u_dec (
      .off (bus_addr[7:0]),
      .size(bus_size),
      .sel (sel_q),
      .dec (dec),
      .idx (idx)
   );

   // redirection table
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
      logic hit_i;
      assign hit_i = acc_wr && dec.redir_hit && (idx == SEL_W'(i));
      irq_route_entry #(.RST_VAL(ENT_RST)) u_ent (
         .clk  (clk),
         .rst_n(rst_n),
         .wr_lo(hit_i && !dec.redir_hi),
         .wr_hi(hit_i &&  dec.redir_hi),
         .wdata(bus_wdata),
         .q    (ent[i])
      );
      assign redir_tbl[i*ENTRY_W +: ENTRY_W] = ent[i];
   end

   // select, ID and service pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
         svc_q <= 1'b0;
      end else begin
         if (acc_wr && dec.sel_hit) sel_q <= bus_wdata[SEL_W-1:0];
         if (acc_wr && dec.is_id)   id_q  <= bus_wdata[ID_LSB +: ID_W];
         svc_q <= acc_wr && dec.redir_hit;
      end
   end
   assign svc_req = svc_q;

   // read mux
   always_comb begin
      rd_word = '0;
      if (dec.sel_hit) begin
         rd_word = 32'(sel_q);
      end else if (dec.is_id || dec.is_arb) begin
         rd_word = {{(32-ID_W){1'b0}}, id_q} << ID_LSB;
      end else if (dec.is_ver) begin
         rd_word = VER_WORD;
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (dec.redir_hit && idx == SEL_W'(i))
               rd_word = dec.redir_hi ? ent[i][63:32] : ent[i][31:0];
         end
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [31:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (acc_rd) rdata_q <= rd_word;
      end
      assign bus_rdata = rdata_q;

      AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_rd |=> $stable(bus_rdata)); // R10
      AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_rd && dec.win_hit && !dec.redir_hit && !dec.is_id && !dec.is_ver && !dec.is_arb)
         |=> (bus_rdata == 32'd0)); // R6
      AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_rd && dec.win_addr && !dec.win_hit) |=> (bus_rdata == 32'd0)); // R2
   end else begin : g_rd_comb
      assign bus_rdata = acc_rd ? rd_word : 32'd0;
   end

   AST_SVC_AFTER_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> $past(bus_req && bus_we && bus_size == 3'd4 && bus_addr[7:0] == 8'(WIN_OFF))); // R8
   AST_NARROW_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && dec.win_addr && !dec.win_hit) |=> $stable(id_q)); // R2
   AST_RO_WRITE_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && (dec.is_ver || dec.is_arb)) |=> $stable(id_q)); // R5

endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;

   localparam int NP = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0;
   logic              bus_we = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [2:0]        bus_size = 3'd4;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              svc_req;
   logic [NP*64-1:0]  redir_tbl;

   int total = 0;
   int bad   = 0;

   // bench model
   logic [63:0] m_ent [NP];
   logic [7:0]  m_sel;
   logic [3:0]  m_id;
   logic [31:0] m_last_rd;

   always #10 clk = ~clk;

   irq_route_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .svc_req(svc_req), .redir_tbl(redir_tbl)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_tbl(input string tag);
      int first_bad = -1;
      total++;
      for (int i = 0; i < NP; i++)
         if (first_bad < 0 && redir_tbl[i*64 +: 64] !== m_ent[i]) first_bad = i;
      if (first_bad >= 0) begin
         bad++;
         $display("FAIL %s entry %0d act=%h exp=%h", tag, first_bad,
                  redir_tbl[first_bad*64 +: 64], m_ent[first_bad]);
      end
   endtask

   function automatic logic in_rng(input logic [7:0] s);
      return (s >= 8'h10) && (((s - 8'h10) >> 1) < 8'(NP));
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a, input logic [2:0] sz);
      logic [7:0] idx;
      if (a[7:0] == 8'h00) return {24'd0, m_sel};
      if (a[7:0] != 8'h10 || sz != 3'd4) return 32'd0;
      if (m_sel == 8'h00 || m_sel == 8'h02) return {4'd0, m_id, 24'd0};
      if (m_sel == 8'h01) return 32'h0017_0011;
      if (!in_rng(m_sel)) return 32'd0;
      idx = (m_sel - 8'h10) >> 1;
      return m_sel[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
   endfunction

   function automatic logic m_redir_wr(input logic [11:0] a, input logic [2:0] sz);
      return a[7:0] == 8'h10 && sz == 3'd4 && in_rng(m_sel);
   endfunction

   task automatic m_write(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] wd);
      logic [7:0] idx;
      if (a[7:0] == 8'h00) begin
         m_sel = wd[7:0];
      end else if (a[7:0] == 8'h10 && sz == 3'd4) begin
         if (m_sel == 8'h00) m_id = wd[27:24];
         else if (in_rng(m_sel)) begin
            idx = (m_sel - 8'h10) >> 1;
            if (m_sel[0]) m_ent[idx][63:32] = wd;
            else          m_ent[idx][31:0]  = wd;
         end
      end
   endtask

   task automatic op(input logic we, input logic [11:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input string tag);
      logic esvc;
      esvc = we && m_redir_wr(a, sz);
      @(negedge clk);
      chk("R8 idle low", 64'(svc_req), 64'd0);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
      if (!we) m_last_rd = m_read(a, sz);
      else     m_write(a, sz, wd);
      @(negedge clk);
      bus_req = 1'b0;
      chk(we ? "R10 hold" : tag, 64'(bus_rdata), 64'(m_last_rd));
      chk(we ? {"R8 ", tag} : "R8 read", 64'(svc_req), 64'(esvc));
      if (we) chk_tbl(tag);
   endtask

   task automatic setsel(input logic [7:0] s);
      op(1'b1, 12'h000, 3'd4, {24'hABCDEF, s}, "R1 select write");
   endtask

   initial begin
      #(20 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
      m_sel = 8'h00; m_id = 4'h0; m_last_rd = 32'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk_tbl("R9 reset table");
      chk("R9 svc after reset", 64'(svc_req), 64'd0);
      op(1'b0, 12'h000, 3'd4, 32'd0, "R9 select reset");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R9 id reset");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R9 arb reset");

      // version and identification
      setsel(8'h01);
      op(1'b0, 12'h010, 3'd4, 32'd0, "R4 version");
      op(1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, "R5 version write ignored");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R5 version unchanged");
      setsel(8'h00);
      op(1'b1, 12'h010, 3'd4, 32'hF5FF_FFFF, "R5 id write");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R5 id readback");
      setsel(8'h02);
      op(1'b0, 12'h010, 3'd4, 32'd0, "R3 arb mirrors id");
      op(1'b1, 12'h010, 3'd4, 32'h0A00_0000, "R5 arb write ignored");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R3 arb after write");

      // redirection halves
      setsel(8'h10);
      op(1'b1, 12'h010, 3'd4, 32'h1234_5678, "R7 low half write");
      setsel(8'h11);
      op(1'b1, 12'h010, 3'd4, 32'hCAFE_F00D, "R7 high half write");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R7 high half read");
      setsel(8'h10);
      op(1'b0, 12'h010, 3'd4, 32'd0, "R7 low half read");
      setsel(8'h3F);
      op(1'b1, 12'h010, 3'd4, 32'h5A5A_0001, "R6 top entry write");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R6 top entry read");
      setsel(8'h40);
      op(1'b1, 12'h010, 3'd4, 32'hDEAD_BEEF, "R6 past-end write dropped");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R6 past-end read zero");
      setsel(8'h0F);
      op(1'b1, 12'h010, 3'd4, 32'hDEAD_BEEF, "R6 below-base write dropped");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R6 below-base read zero");
      setsel(8'h03);
      op(1'b0, 12'h010, 3'd4, 32'd0, "R6 gap read zero");

      // size rule
      setsel(8'h12);
      op(1'b1, 12'h010, 3'd2, 32'h7777_7777, "R2 narrow write ignored");
      op(1'b1, 12'h010, 3'd1, 32'h7777_7777, "R2 byte write ignored");
      op(1'b0, 12'h010, 3'd2, 32'd0, "R2 narrow read zero");
      setsel(8'h00);
      op(1'b1, 12'h010, 3'd2, 32'h0300_0000, "R2 narrow id write ignored");
      op(1'b0, 12'h010, 3'd4, 32'd0, "R2 id unchanged");

      // offset decode
      op(1'b0, 12'h020, 3'd4, 32'd0, "R1 unmapped offset read");
      op(1'b1, 12'h020, 3'd4, 32'h0000_0013, "R1 unmapped offset write");
      op(1'b0, 12'hF00, 3'd1, 32'd0, "R1 select at high address");
      op(1'b1, 12'hA00, 3'd2, 32'h0000_0014, "R1 select write high address");
      op(1'b1, 12'h710, 3'd4, 32'h0BAD_CAFE, "R1 window at high address");
      op(1'b0, 12'h310, 3'd4, 32'd0, "R1 window read high address");

      // random mix
      for (int k = 0; k < 700; k++) begin
         logic [11:0] a;
         logic [2:0]  sz;
         logic [31:0] wd;
         logic        we;
         int          r;
         string       tag;
         r = int'($urandom % 8);
         a[11:8] = 4'($urandom);
         if (r < 3)      a[7:0] = 8'h00;
         else if (r < 7) a[7:0] = 8'h10;
         else            a[7:0] = 8'($urandom);
         r = int'($urandom % 6);
         sz = (r < 3) ? 3'd4 : (r == 3) ? 3'd1 : (r == 4) ? 3'd2 : 3'(r);
         we = 1'($urandom);
         wd = $urandom;
         if (a[7:0] == 8'h00 && ($urandom % 4) != 0) wd[7:0] = 8'($urandom % 8'h48);
         if (a[7:0] == 8'h00)                        tag = "R1 rand select";
         else if (a[7:0] != 8'h10)                   tag = "R1 rand other offset";
         else if (sz != 3'd4)                        tag = "R2 rand narrow";
         else if (m_sel == 8'h00)                    tag = "R5 rand id";
         else if (m_sel == 8'h02)                    tag = "R3 rand arb";
         else if (m_sel == 8'h01)                    tag = "R4 rand version";
         else if (in_rng(m_sel))                     tag = "R7 rand entry";
         else                                        tag = "R6 rand out of range";
         op(we, a, sz, wd, tag);
      end

      @(negedge clk);
      chk("R8 final idle", 64'(svc_req), 64'd0);
      chk_tbl("R7 final table");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule